// File: doc/BRIEF.md
# Next-Fit Contiguous Page Allocator

This block tracks which pages of a remapping window are in use, one bit per page. A requester asks for a run of N consecutive free pages. The run must meet an alignment mask and must not straddle a segment boundary. The block returns the first page of the run, or a failure code. A separate free command gives a run back. The lowest pages of the window form a reserved emergency area. They are marked used from reset and are never returned.

The search is next-fit. It starts at a roving pointer, tests one page per clock cycle, and makes a second pass from page 0 if the first pass finds nothing. A wrap of the pointer or a second pass leaves stale translations possible, so the block raises a flush-pending flag when either happens. In full-flush mode every successful allocation raises the flag as well. A flush command clears the flag through a request/acknowledge handshake with the translation cache, but only when the flag is set.

Top module: `page_run_alloc`

## Requirements
- R1: After reset `busy`, `done`, `flush_pending` and `flush_out` are low. Pages 0 to RSV_PAGES-1 (32 by default) are never returned as, or inside, an allocated run.
- R2: An allocation of 0 pages, or of more than PAGES pages, fails. `done` is high in the cycle after the request is taken, and only for that one cycle. Neither the pointer nor the flag changes.
- R3: The first pass searches upward from the pointer. It returns the lowest legal free start at or above the pointer.
- R4: If the first pass finds nothing, `flush_pending` is set and the search repeats from page 0.
- R5: On success the pointer becomes start+size. If that value is PAGES or more, the pointer becomes 0 and `flush_pending` is set. A run never extends past page PAGES-1.
- R6: A returned start S satisfies (S & `align_mask`) == 0.
- R7: `seg_pages` must be a power of two. For a returned run of N pages starting at S, floor((S+`seg_base`)/`seg_pages`) equals floor((S+`seg_base`+N-1)/`seg_pages`).
- R8: A failed allocation reports `ok`=0 with `run_start` all ones (127 by default).
- R9: A free makes pages usable again, except reserved pages. If the freed start is at or above the pointer, the pointer becomes start+size.
- R10: With `full_flush_mode` high when the request is taken, a successful allocation sets `flush_pending`.
- R11: A flush command with `flush_pending` set raises `flush_out` in the next cycle. `flush_out` stays high until `flush_ack`, and the edge that sees the acknowledge clears both `flush_out` and `flush_pending`.
- R12: A flush command with `flush_pending` clear leaves `flush_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_flush_mode | input | 1 | Every successful allocation requests a flush |
| alloc_req | input | 1 | Allocation request, taken when idle |
| alloc_pages | input | CW | Pages requested |
| align_mask | input | IW | Start alignment mask |
| seg_base | input | IW | Offset added before the boundary test |
| seg_pages | input | CW | Segment size in pages, power of two |
| free_req | input | 1 | Free request, taken when idle and no allocation is asked |
| free_start | input | IW | First page to free |
| free_pages | input | CW | Pages to free |
| flush_cmd | input | 1 | Flush command, lowest priority |
| flush_ack | input | 1 | Flush completion from the translation cache |
| busy | output | 1 | Search or flush in progress |
| done | output | 1 | One-cycle allocation result strobe |
| ok | output | 1 | Allocation succeeded (valid with done) |
| run_start | output | CW | Start page, or all ones on failure |
| flush_pending | output | 1 | Flush needed |
| flush_out | output | 1 | Flush request to the translation cache |

## Verification
A short directed sequence runs first. It targets a misaligned pointer, a run that would straddle a segment boundary, a free above the pointer, a run ending exactly at the top page, and full-flush mode. Each of these separates next-fit from lowest-fit, or pointer wrap from no wrap.

A sweep of several hundred requests then cycles through sizes, masks, segment sizes and bases, with delayed frees. Every result and every flag value is compared with a bench model that counts segments by division. Exhausting the map tells a genuine all-full failure apart from a second-pass success. Flush commands are issued both with and without a pending flag, and the acknowledge is withheld for several cycles.

// File: rtl/page_run_alloc_pkg.sv
package page_run_alloc_pkg;

  typedef enum logic [0:0] {SCAN_IDLE, SCAN_RUN} scan_st_e;

  // Alignment and segment containment of a candidate run; bpages is a power of two.
  function automatic logic run_geometry_ok(input int unsigned s, input int unsigned n,
                                           input int unsigned amask, input int unsigned bbase,
                                           input int unsigned bpages);
    int unsigned lo;
    int unsigned hi;
    lo = s + bbase;
    hi = lo + n - 1;
    return ((s & amask) == 0) && (n <= bpages) && (((lo ^ hi) & ~(bpages - 1)) == 0);
  endfunction

  function automatic logic size_legal(input int unsigned n, input int unsigned pages);
    return (n != 0) && (n <= pages);
  endfunction

endpackage

// File: rtl/page_run_map.sv
module page_run_map #(
  parameter int PAGES     = 64,
  parameter int RSV_PAGES = 32,
  parameter int IW        = 6,
  parameter int CW        = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [CW-1:0] set_start,
  input  logic [CW-1:0] set_len,
  input  logic          clr_en,
  input  logic [CW-1:0] clr_start,
  input  logic [CW-1:0] clr_len,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_used
);
  function automatic logic [PAGES-1:0] low_mask();
    logic [PAGES-1:0] m;
    for (int i = 0; i < PAGES; i++) m[i] = (i < RSV_PAGES);
    return m;
  endfunction

  localparam logic [PAGES-1:0] KEEP = low_mask();

  function automatic logic [PAGES-1:0] span(input logic [CW-1:0] st, input logic [CW-1:0] len);
    logic [PAGES-1:0] m;
    for (int i = 0; i < PAGES; i++) m[i] = (i >= int'(st)) && (i < int'(st) + int'(len));
    return m;
  endfunction

  logic [PAGES-1:0] used_q, used_d;

  always_comb begin
    used_d = used_q;
    if (set_en) used_d = used_d | span(set_start, set_len);
    if (clr_en) used_d = (used_d & ~span(clr_start, clr_len)) | KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= KEEP;
    else        used_q <= used_d;
  end

  assign rd_used = used_q[rd_idx];
endmodule

// File: rtl/page_run_flush.sv
module page_run_flush (
  input  logic clk,
  input  logic rst_n,
  input  logic set_need,
  input  logic go,
  input  logic ack,
  output logic need,
  output logic req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      need <= 1'b0;
      req  <= 1'b0;
    end else if (req && ack) begin
      req  <= 1'b0;
      need <= 1'b0;
    end else begin
      if (set_need)    need <= 1'b1;
      if (go && need)  req  <= 1'b1;
    end
  end
endmodule

// File: rtl/page_run_alloc.sv
module page_run_alloc #(
  parameter int PAGES     = 64,
  parameter int RSV_PAGES = 32,
  localparam int IW = $clog2(PAGES),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_flush_mode,
  input  logic          alloc_req,
  input  logic [CW-1:0] alloc_pages,
  input  logic [IW-1:0] align_mask,
  input  logic [IW-1:0] seg_base,
  input  logic [CW-1:0] seg_pages,
  input  logic          free_req,
  input  logic [IW-1:0] free_start,
  input  logic [CW-1:0] free_pages,
  input  logic          flush_cmd,
  input  logic          flush_ack,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic [CW-1:0] run_start,
  output logic          flush_pending,
  output logic          flush_out
);
  import page_run_alloc_pkg::*;

  localparam logic [CW-1:0] FAIL_CODE = '1;
  localparam logic [CW:0]   PAGES_W   = (CW+1)'(PAGES);

  scan_st_e      st;
  logic [CW-1:0] cand, cnt, ptr_q;
  logic          second;
  logic [CW-1:0] n_q, bs_q;
  logic [IW-1:0] mask_q, bb_q;
  logic          mode_q;
  logic          done_q, ok_q;
  logic [CW-1:0] start_q;

  // Named events for the checker and the datapath
  logic          idle, accept_alloc, accept_free, flush_go;
  logic          end_over, geo_ok, rd_used;
  logic          ev_pass_fail, ev_skip, ev_hit, ev_found, wrap, set_need;
  logic [CW-1:0] probe;
  logic [CW:0]   next_end;

  assign idle         = (st == SCAN_IDLE) && !flush_out;
  assign accept_alloc = idle && alloc_req;
  assign accept_free  = idle && !alloc_req && free_req;
  assign flush_go     = idle && !alloc_req && !free_req && flush_cmd;

  assign end_over = (32'(cand) + 32'(n_q)) > 32'(PAGES);
  assign geo_ok   = run_geometry_ok(32'(cand), 32'(n_q), 32'(mask_q), 32'(bb_q), 32'(bs_q));
  assign probe    = cand + cnt;
  assign next_end = {1'b0, cand} + {1'b0, n_q};
  assign wrap     = next_end >= PAGES_W;

  assign ev_pass_fail = (st == SCAN_RUN) && end_over;
  assign ev_skip      = (st == SCAN_RUN) && !end_over && !geo_ok;
  assign ev_hit       = (st == SCAN_RUN) && !end_over && geo_ok && rd_used;
  assign ev_found     = (st == SCAN_RUN) && !end_over && geo_ok && !rd_used && (cnt == n_q - 1'b1);
  assign set_need     = (ev_pass_fail && !second) || (ev_found && (wrap || mode_q));

  page_run_map #(.PAGES(PAGES), .RSV_PAGES(RSV_PAGES), .IW(IW), .CW(CW)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (ev_found),
    .set_start (cand),
    .set_len   (n_q),
    .clr_en    (accept_free),
    .clr_start ({1'b0, free_start}),
    .clr_len   (free_pages),
    .rd_idx    (probe[IW-1:0]),
    .rd_used   (rd_used)
  );

  page_run_flush u_flush (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_need (set_need),
    .go       (flush_go),
    .ack      (flush_ack),
    .need     (flush_pending),
    .req      (flush_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SCAN_IDLE;
      cand    <= '0;
      cnt     <= '0;
      second  <= 1'b0;
      ptr_q   <= '0;
      n_q     <= '0;
      bs_q    <= '0;
      mask_q  <= '0;
      bb_q    <= '0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      start_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_alloc) begin
        n_q    <= alloc_pages;
        mask_q <= align_mask;
        bb_q   <= seg_base;
        bs_q   <= seg_pages;
        mode_q <= full_flush_mode;
        if (!size_legal(32'(alloc_pages), 32'(PAGES))) begin
          done_q  <= 1'b1;
          ok_q    <= 1'b0;
          start_q <= FAIL_CODE;
        end else begin
          st     <= SCAN_RUN;
          cand   <= ptr_q;
          cnt    <= '0;
          second <= 1'b0;
        end
      end else if (accept_free) begin
        if ({1'b0, free_start} >= ptr_q) ptr_q <= {1'b0, free_start} + free_pages;
      end else if (st == SCAN_RUN) begin
        if (ev_pass_fail) begin
          if (second) begin
            st      <= SCAN_IDLE;
            done_q  <= 1'b1;
            ok_q    <= 1'b0;
            start_q <= FAIL_CODE;
          end else begin
            second <= 1'b1;
            cand   <= '0;
            cnt    <= '0;
          end
        end else if (ev_skip) begin
          cand <= cand + 1'b1;
          cnt  <= '0;
        end else if (ev_hit) begin
          cand <= probe + 1'b1;
          cnt  <= '0;
        end else if (ev_found) begin
          st      <= SCAN_IDLE;
          done_q  <= 1'b1;
          ok_q    <= 1'b1;
          start_q <= cand;
          ptr_q   <= wrap ? '0 : next_end[CW-1:0];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign busy      = (st == SCAN_RUN) || flush_out;
  assign done      = done_q;
  assign ok        = ok_q;
  assign run_start = start_q;
endmodule

// File: rtl/page_run_alloc_chk.sv
module page_run_alloc_chk #(
  parameter int PAGES     = 64,
  parameter int RSV_PAGES = 32,
  parameter int IW        = 6,
  parameter int CW        = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          ok,
  input logic [CW-1:0] run_start,
  input logic [CW-1:0] n_q,
  input logic [IW-1:0] mask_q,
  input logic [IW-1:0] bb_q,
  input logic [CW-1:0] bs_q,
  input logic          mode_q,
  input logic          flush_pending,
  input logic          flush_out,
  input logic          flush_ack
);
  assert_fail_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ok |-> run_start == '1);

  assert_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> 32'(run_start) >= 32'(RSV_PAGES));

  assert_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> (run_start[IW-1:0] & mask_q) == '0);

  assert_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> 32'(run_start) + 32'(n_q) <= 32'(PAGES));

  assert_segment_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> ((32'(run_start) + 32'(bb_q)) / 32'(bs_q)) ==
                   ((32'(run_start) + 32'(bb_q) + 32'(n_q) - 1) / 32'(bs_q)));

  assert_full_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok && mode_q |-> flush_pending);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_flush_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_out && !flush_ack |=> flush_out);

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_pending) |-> $past(flush_ack));

  assert_req_needs_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flush_out |-> flush_pending);
endmodule

bind page_run_alloc page_run_alloc_chk #(.PAGES(PAGES), .RSV_PAGES(RSV_PAGES), .IW(IW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .done          (done),
  .ok            (ok),
  .run_start     (run_start),
  .n_q           (n_q),
  .mask_q        (mask_q),
  .bb_q          (bb_q),
  .bs_q          (bs_q),
  .mode_q        (mode_q),
  .flush_pending (flush_pending),
  .flush_out     (flush_out),
  .flush_ack     (flush_ack)
);

// File: tb/page_run_alloc_test.sv
module page_run_alloc_test;
  localparam int CLK_PERIOD = 10;
  localparam int P   = 64;
  localparam int RSV = 32;
  localparam int IW  = 6;
  localparam int CW  = 7;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fm = 1'b0, alloc_req = 1'b0, free_req = 1'b0, flush_cmd = 1'b0, flush_ack = 1'b0;
  logic [CW-1:0] alloc_pages = '0, seg_pages = '0, free_pages = '0;
  logic [IW-1:0] align_mask = '0, seg_base = '0, free_start = '0;
  logic busy, done, ok, flush_pending, flush_out;
  logic [CW-1:0] run_start;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_run_alloc #(.PAGES(P), .RSV_PAGES(RSV)) uut (
    .clk(clk), .rst_n(rst_n), .full_flush_mode(fm),
    .alloc_req(alloc_req), .alloc_pages(alloc_pages), .align_mask(align_mask),
    .seg_base(seg_base), .seg_pages(seg_pages),
    .free_req(free_req), .free_start(free_start), .free_pages(free_pages),
    .flush_cmd(flush_cmd), .flush_ack(flush_ack),
    .busy(busy), .done(done), .ok(ok), .run_start(run_start),
    .flush_pending(flush_pending), .flush_out(flush_out)
  );

  int total = 0, fails = 0, cyc = 0;
  bit finished = 0;
  bit mused [P];
  int mptr = 0;
  bit mflag = 0;
  int rs [400];
  int rn [400];

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      report();
    end
  end

  function automatic int m_search(input int from, input int n, input int mask,
                                  input int bb, input int bs);
    for (int s = from; s + n <= P; s++) begin
      bit good;
      good = ((s & mask) == 0) && (((s + bb) / bs) == ((s + bb + n - 1) / bs));
      for (int i = 0; i < n; i++) if (good && mused[s + i]) good = 0;
      if (good) return s;
    end
    return -1;
  endfunction

  // Drives one allocation and compares with the model; got is -1 on failure.
  task automatic do_alloc(input int n, input int mask, input int bb, input int bs,
                          input string tag, output int got);
    int exp, waited;
    bit retried;
    exp = -1;
    retried = 0;
    if (n != 0 && n <= P) begin
      exp = m_search(mptr, n, mask, bb, bs);
      if (exp < 0) begin
        mflag = 1; retried = 1;
        exp = m_search(0, n, mask, bb, bs);
      end
      if (exp >= 0) begin
        for (int i = 0; i < n; i++) mused[exp + i] = 1;
        mptr = exp + n;
        if (mptr >= P) begin mptr = 0; mflag = 1; end
        if (fm) mflag = 1;
      end
    end
    @(negedge clk);
    alloc_req = 1; alloc_pages = CW'(n); align_mask = IW'(mask);
    seg_base = IW'(bb); seg_pages = CW'(bs);
    @(negedge clk);
    alloc_req = 0;
    waited = 1;
    while (!done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    got = ok ? int'(run_start) : -1;
    if (exp < 0) begin
      chk(!ok && run_start == '1, "R8 fail code", int'(run_start), 127);
      if (n == 0 || n > P) chk(waited == 1, "R2 bad size one-cycle fail", waited, 1);
    end else begin
      chk(ok && got == exp, retried ? "R4 retry from zero" : tag, got, exp);
      chk(got >= RSV, "R1 reserved never returned", got, RSV);
      chk((got & mask) == 0, "R6 alignment", got & mask, 0);
      chk(((got + bb) / bs) == ((got + bb + n - 1) / bs), "R7 segment boundary", got, exp);
    end
    chk(flush_pending == mflag, "R5 flush pending after alloc", int'(flush_pending), int'(mflag));
  endtask

  task automatic do_free(input int st, input int len);
    for (int i = st; i < st + len && i < P; i++) if (i >= RSV) mused[i] = 0;
    if (st >= mptr) mptr = st + len;
    @(negedge clk);
    free_req = 1; free_start = IW'(st); free_pages = CW'(len);
    @(negedge clk);
    free_req = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_cmd = 1;
    @(negedge clk);
    flush_cmd = 0;
    if (!mflag) begin
      chk(flush_out == 0, "R12 no flush when not pending", int'(flush_out), 0);
    end else begin
      chk(flush_out == 1, "R11 flush request raised", int'(flush_out), 1);
      repeat (3) @(negedge clk);
      chk(flush_out == 1 && flush_pending == 1, "R11 held until ack", int'(flush_out), 1);
      flush_ack = 1;
      @(negedge clk);
      flush_ack = 0;
      chk(flush_out == 0 && flush_pending == 0, "R11 cleared by ack",
          int'(flush_out) + int'(flush_pending), 0);
      mflag = 0;
    end
  endtask

  initial begin
    int got;
    for (int i = 0; i < P; i++) mused[i] = (i < RSV);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !flush_pending && !flush_out, "R1 reset state",
        int'(busy) + int'(done) + int'(flush_pending) + int'(flush_out), 0);
    rst_n = 1;
    @(negedge clk);

    // Bad sizes
    do_alloc(0, 0, 0, 64, "R2", got);
    do_alloc(65, 0, 0, 64, "R2", got);

    // Directed: first page, misaligned pointer, boundary skip, next-fit past a hole
    do_alloc(1, 0, 0, 64, "R3 first free page", got);    // 32
    do_alloc(4, 3, 0, 64, "R6 aligned start", got);      // 36
    do_alloc(3, 0, 2, 4, "R7 boundary skip", got);       // 42
    do_free(32, 1);
    do_alloc(1, 0, 0, 64, "R3 next-fit past hole", got); // 45
    do_free(50, 2);
    do_alloc(1, 0, 0, 64, "R9 pointer moved by free", got); // 52
    do_alloc(11, 0, 0, 64, "R5 run ending at top wraps", got); // 53, wrap
    do_flush();
    do_flush();
    fm = 1;
    do_alloc(1, 0, 0, 64, "R10 full flush mode", got);
    chk(flush_pending == 1, "R10 pending set", int'(flush_pending), 1);
    fm = 0;
    do_flush();

    // Sweep of sizes, masks, segments with delayed frees
    for (int k = 0; k < 300; k++) begin
      int n, mask, bs, bb;
      n    = 1 + (k % 5);
      mask = (1 << ((k / 5) % 3)) - 1;
      bs   = 4 << (k % 4);
      bb   = (k * 3) % 8;
      do_alloc(n, mask, bb, bs, "R3 sweep", got);
      rs[k] = got; rn[k] = n;
      if (k >= 3 && rs[k-3] >= 0) do_free(rs[k-3], rn[k-3]);
      if (k % 10 == 9) do_flush();
    end

    // Exhaust the map
    got = 0;
    for (int k = 0; k < 40 && got >= 0; k++) do_alloc(1, 0, 0, 64, "R3 fill", got);
    chk(got < 0, "R8 full map fails", got, -1);
    do_free(40, 2);
    do_alloc(2, 0, 0, 64, "R9 freed run reused", got);
    chk(got == 40, "R9 freed run start", got, 40);
    do_flush();

    report();
  end
endmodule